// File: doc/BRIEF.md
# Dual-Standard Raster Timing Generator

This block produces the beam timing for a video output that runs either 525-style (NTSC) or 625-style (PAL) scanning, counted in GPU clock ticks. It holds a tick-within-line counter and a line counter. From them it derives the horizontal and vertical blanking flags, and it reports the beam position and an interlace field bit. Every counter step is qualified by a tick-enable input. The block therefore sits in any clock domain whose clock is at least as fast as the GPU tick rate.

Three inputs set the geometry. The standard select picks the line length, the line count and the window edges, but it is only taken up when a frame wraps, so a frame in progress is never cut short. The crop select swaps, at once, the full active window for a narrower window with the overscan cut away. Each window edge is inclusive at its start and exclusive at its end. The interlace enable lets the field bit flip once per frame.

Top module: `raster_timer`

## Requirements
- R1: While rst_n is low, beam_x and beam_y are 0, field is 0, and pal_active follows pal_sel.
- R2: beam_x and beam_y change only on a clock edge where tick_en is 1. On such an edge beam_x goes up by one. From the last tick of a line (line length minus 1) it goes to 0 instead, and beam_y goes up by one.
- R3: On a tick from the last tick of the last line, beam_y returns to 0. This is the frame wrap. A line is 3413 ticks and a frame is 263 lines when pal_active is 0. A line is 3406 ticks and a frame is 314 lines when pal_active is 1.
- R4: With crop_en at 0, hblank is 0 only for beam_x in [488, 3288) when pal_active is 0, and only for beam_x in [488, 3300) when pal_active is 1.
- R5: With crop_en at 0, vblank is 0 only for beam_y in [16, 256) when pal_active is 0, and only for beam_y in [20, 308) when pal_active is 1.
- R6: With crop_en at 1, the unblanked window narrows. When pal_active is 0 it is beam_x in [608, 3168) and beam_y in [24, 248). When pal_active is 1 it is beam_x in [628, 3188) and beam_y in [30, 298). A change of crop_en acts on hblank and vblank in the same cycle.
- R7: With interlace_en at 1, field inverts at every frame wrap. An edge with interlace_en at 0 sets field to 0. Field value 0 means odd lines are shown and 1 means even lines are shown.
- R8: pal_active (1 = PAL geometry) takes the value of pal_sel only at a frame wrap or during reset. A change of pal_sel mid-frame leaves the line length, line count and windows unchanged until that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the beam by one GPU tick |
| pal_sel | input | 1 | Requested standard, 1 = PAL, 0 = NTSC |
| crop_en | input | 1 | Uses the overscan-cropped window for blanking |
| interlace_en | input | 1 | Lets the field bit alternate per frame |
| beam_x | output | XW | Tick within the current line |
| beam_y | output | YW | Current line within the frame |
| hblank | output | 1 | Beam outside the horizontal window |
| vblank | output | 1 | Beam outside the vertical window |
| field | output | 1 | Interlace field, 0 odd, 1 even |
| pal_active | output | 1 | Standard currently in use |

## Verification
The properties assume the select inputs change only between clock edges. The bench keeps to this by driving them on the falling edge. They also assume that a change of crop_en or of the active standard is the only cause of a blanking edge other than beam movement. The stimulus changes pal_sel and interlace_en only at ticks that are known in advance, so the expected positions stay predictable. The bench runs a second, scaled-down instance alongside the default one. This lets frame wraps, field flips and the deferred standard switch occur within a short run, while the default instance covers the real horizontal edges and the first vertical edges.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int NTSC_LINE   = 3413,
  parameter int NTSC_FRAME  = 263,
  parameter int PAL_LINE    = 3406,
  parameter int PAL_FRAME   = 314,
  parameter int NTSC_HA_BEG = 488,
  parameter int NTSC_HA_END = 3288,
  parameter int NTSC_VA_BEG = 16,
  parameter int NTSC_VA_END = 256,
  parameter int NTSC_HC_BEG = 608,
  parameter int NTSC_HC_END = 3168,
  parameter int NTSC_VC_BEG = 24,
  parameter int NTSC_VC_END = 248,
  parameter int PAL_HA_BEG  = 488,
  parameter int PAL_HA_END  = 3300,
  parameter int PAL_VA_BEG  = 20,
  parameter int PAL_VA_END  = 308,
  parameter int PAL_HC_BEG  = 628,
  parameter int PAL_HC_END  = 3188,
  parameter int PAL_VC_BEG  = 30,
  parameter int PAL_VC_END  = 298,
  localparam int XW = $clog2((NTSC_LINE > PAL_LINE) ? NTSC_LINE : PAL_LINE),
  localparam int YW = $clog2((NTSC_FRAME > PAL_FRAME) ? NTSC_FRAME : PAL_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          pal_sel,
  input  logic          crop_en,
  input  logic          interlace_en,
  output logic [XW-1:0] beam_x,
  output logic [YW-1:0] beam_y,
  output logic          hblank,
  output logic          vblank,
  output logic          field,
  output logic          pal_active
);

  localparam logic [XW-1:0] N_XLAST = XW'(NTSC_LINE - 1);
  localparam logic [XW-1:0] P_XLAST = XW'(PAL_LINE - 1);
  localparam logic [YW-1:0] N_YLAST = YW'(NTSC_FRAME - 1);
  localparam logic [YW-1:0] P_YLAST = YW'(PAL_FRAME - 1);

  logic [XW-1:0] x_last, h_beg, h_end;
  logic [YW-1:0] y_last, v_beg, v_end;
  logic          end_x, end_y, wrap;

  assign x_last = pal_active ? P_XLAST : N_XLAST;
  assign y_last = pal_active ? P_YLAST : N_YLAST;
  assign end_x  = (beam_x == x_last);
  assign end_y  = (beam_y == y_last);
  assign wrap   = tick_en & end_x & end_y;

  always_comb begin
    case ({pal_active, crop_en})
      2'b00: begin
        h_beg = XW'(NTSC_HA_BEG); h_end = XW'(NTSC_HA_END);
        v_beg = YW'(NTSC_VA_BEG); v_end = YW'(NTSC_VA_END);
      end
      2'b01: begin
        h_beg = XW'(NTSC_HC_BEG); h_end = XW'(NTSC_HC_END);
        v_beg = YW'(NTSC_VC_BEG); v_end = YW'(NTSC_VC_END);
      end
      2'b10: begin
        h_beg = XW'(PAL_HA_BEG); h_end = XW'(PAL_HA_END);
        v_beg = YW'(PAL_VA_BEG); v_end = YW'(PAL_VA_END);
      end
      default: begin
        h_beg = XW'(PAL_HC_BEG); h_end = XW'(PAL_HC_END);
        v_beg = YW'(PAL_VC_BEG); v_end = YW'(PAL_VC_END);
      end
    endcase
  end

  assign hblank = (beam_x < h_beg) || (beam_x >= h_end);
  assign vblank = (beam_y < v_beg) || (beam_y >= v_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beam_x     <= '0;
      beam_y     <= '0;
      field      <= 1'b0;
      pal_active <= pal_sel;
    end else begin
      if (tick_en) beam_x <= end_x ? '0 : beam_x + 1'b1;
      if (tick_en && end_x) beam_y <= end_y ? '0 : beam_y + 1'b1;
      if (wrap) pal_active <= pal_sel;
      if (!interlace_en) field <= 1'b0;
      else if (wrap) field <= ~field;
    end
  end

endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int XW = 12,
  parameter int YW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          crop_en,
  input logic          interlace_en,
  input logic [XW-1:0] beam_x,
  input logic [YW-1:0] beam_y,
  input logic          hblank,
  input logic          vblank,
  input logic          field,
  input logic          pal_active
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(beam_x) && $stable(beam_y));

  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (beam_x == XW'($past(beam_x) + 1'b1)) || (beam_x == '0));

  // R3
  y_moves_at_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(beam_y) |-> beam_x == '0);

  // R8
  std_switch_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pal_active) |-> (beam_x == '0) && (beam_y == '0));

  // R7
  field_flip_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) && $past(interlace_en) |-> (beam_x == '0) && (beam_y == '0));

  // R7
  field_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(interlace_en) |-> !field);

  // R4
  hblank_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hblank) |-> !$stable(beam_x) || !$stable(crop_en) || !$stable(pal_active));

  // R5
  vblank_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vblank) |-> !$stable(beam_y) || !$stable(crop_en) || !$stable(pal_active));

endmodule

bind raster_timer raster_timer_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .crop_en(crop_en),
  .interlace_en(interlace_en), .beam_x(beam_x), .beam_y(beam_y),
  .hblank(hblank), .vblank(vblank), .field(field), .pal_active(pal_active)
);

// File: tb/sim_raster_timer.sv
module sim_raster_timer;

  typedef struct {
    int    inst;
    int    t;
    int    x;
    int    y;
    bit    hb;
    bit    vb;
    bit    fld;
    bit    pal;
    string req;
  } item_t;

  logic clk = 1'b0;
  always #10ns clk = ~clk;

  logic rst_n = 1'b0, tick_en = 1'b1, pal_sel = 1'b0, crop_en = 1'b0, il = 1'b0;
  logic [11:0] x0; logic [8:0] y0; logic hb0, vb0, fd0, pa0;
  logic [4:0]  x1; logic [3:0] y1; logic hb1, vb1, fd1, pa1;

  int nchk = 0, nfail = 0, tcnt = 0;
  item_t sb[$];

  raster_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pal_sel(pal_sel), .crop_en(crop_en),
    .interlace_en(il), .beam_x(x0), .beam_y(y0), .hblank(hb0), .vblank(vb0),
    .field(fd0), .pal_active(pa0));

  raster_timer #(
    .NTSC_LINE(20), .NTSC_FRAME(13), .PAL_LINE(18), .PAL_FRAME(15),
    .NTSC_HA_BEG(4), .NTSC_HA_END(16), .NTSC_VA_BEG(2), .NTSC_VA_END(10),
    .NTSC_HC_BEG(6), .NTSC_HC_END(14), .NTSC_VC_BEG(3), .NTSC_VC_END(9),
    .PAL_HA_BEG(4), .PAL_HA_END(15), .PAL_VA_BEG(3), .PAL_VA_END(12),
    .PAL_HC_BEG(6), .PAL_HC_END(13), .PAL_VC_BEG(4), .PAL_VC_END(11)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pal_sel(pal_sel), .crop_en(crop_en),
    .interlace_en(il), .beam_x(x1), .beam_y(y1), .hblank(hb1), .vblank(vb1),
    .field(fd1), .pal_active(pa1));

  always @(posedge clk)
    if (!rst_n) tcnt <= 0;
    else if (tick_en) tcnt <= tcnt + 1;

  function automatic item_t calc(int inst, int t, bit pal, bit crop, bit ilc, string req);
    item_t e;
    int L, N, hs, he, vs, ve, fr;
    if (inst == 0) begin
      L  = pal ? 3406 : 3413;  N  = pal ? 314 : 263;
      hs = crop ? (pal ? 628 : 608) : 488;
      he = crop ? (pal ? 3188 : 3168) : (pal ? 3300 : 3288);
      vs = crop ? (pal ? 30 : 24) : (pal ? 20 : 16);
      ve = crop ? (pal ? 298 : 248) : (pal ? 308 : 256);
    end else begin
      L  = pal ? 18 : 20;  N  = pal ? 15 : 13;
      hs = crop ? 6 : 4;
      he = crop ? (pal ? 13 : 14) : (pal ? 15 : 16);
      vs = crop ? (pal ? 4 : 3) : (pal ? 3 : 2);
      ve = crop ? (pal ? 11 : 9) : (pal ? 12 : 10);
    end
    fr     = t / (L * N);
    e.inst = inst;  e.t = t;  e.req = req;  e.pal = pal;
    e.x    = t % L;
    e.y    = (t / L) % N;
    e.fld  = ilc ? fr[0] : 1'b0;
    e.hb   = (e.x < hs) || (e.x >= he);
    e.vb   = (e.y < vs) || (e.y >= ve);
    return e;
  endfunction

  task automatic q(int inst, int t, bit pal, bit crop, bit ilc, string req);
    sb.push_back(calc(inst, t, pal, crop, ilc, req));
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t e;
    int ax, ay;
    bit ah, av, af, ap;
    while (rst_n && sb.size() > 0 && sb[0].t <= tcnt) begin
      e = sb.pop_front();
      if (e.inst == 0) begin ax = x0; ay = y0; ah = hb0; av = vb0; af = fd0; ap = pa0; end
      else             begin ax = x1; ay = y1; ah = hb1; av = vb1; af = fd1; ap = pa1; end
      nchk++;
      if (e.t < tcnt) begin
        nfail++;
        $display("FAIL %s inst%0d tick missed actual=%0d expected=%0d", e.req, e.inst, tcnt, e.t);
      end else if (ax != e.x || ay != e.y || ah != e.hb || av != e.vb || af != e.fld || ap != e.pal) begin
        nfail++;
        $display("FAIL %s inst%0d t=%0d actual x=%0d y=%0d hb=%0d vb=%0d f=%0d p=%0d expected x=%0d y=%0d hb=%0d vb=%0d f=%0d p=%0d",
                 e.req, e.inst, e.t, ax, ay, ah, av, af, ap, e.x, e.y, e.hb, e.vb, e.fld, e.pal);
      end
    end
  end

  task automatic start(bit pal, bit crop, bit ilc);
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b1; pal_sel = pal; crop_en = crop; il = ilc;
    repeat (3) @(negedge clk);
    // R1 reset state of both instances
    chk(x0 == 0 && y0 == 0, "R1", "u0 position", x0 + y0, 0);
    chk(x1 == 0 && y1 == 0, "R1", "u1 position", x1 + y1, 0);
    chk(fd0 == 0 && fd1 == 0, "R1", "field", fd0 + fd1, 0);
    chk(pa0 == pal && pa1 == pal, "R1", "standard", pa0 + pa1, 2 * pal);
  endtask

  task automatic go_and_drain();
    rst_n = 1'b1;
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic wait_tick(int t);
    while (tcnt != t) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tcnt, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    // NTSC, full window, no interlace
    start(0, 0, 0);
    q(0, 0, 0, 0, 0, "R2");    q(1, 0, 0, 0, 0, "R2");
    q(1, 3, 0, 0, 0, "R4");    q(1, 4, 0, 0, 0, "R4");
    q(1, 15, 0, 0, 0, "R4");   q(1, 16, 0, 0, 0, "R4");
    q(1, 19, 0, 0, 0, "R2");   q(1, 20, 0, 0, 0, "R2");
    q(1, 39, 0, 0, 0, "R5");   q(1, 40, 0, 0, 0, "R5");
    q(1, 199, 0, 0, 0, "R5");  q(1, 200, 0, 0, 0, "R5");
    q(1, 259, 0, 0, 0, "R3");  q(1, 260, 0, 0, 0, "R3");
    q(0, 487, 0, 0, 0, "R4");  q(0, 488, 0, 0, 0, "R4");
    q(0, 3287, 0, 0, 0, "R4"); q(0, 3288, 0, 0, 0, "R4");
    q(0, 3412, 0, 0, 0, "R2"); q(0, 3413, 0, 0, 0, "R2");
    q(0, 54607, 0, 0, 0, "R5"); q(0, 54608, 0, 0, 0, "R5");
    rst_n = 1'b1;
    wait_tick(100);
    tick_en = 1'b0;
    repeat (6) @(negedge clk);
    // R2 counters frozen while tick_en is low
    chk(x0 == 100 && y0 == 0, "R2", "u0 x frozen", x0, 100);
    chk(x1 == 0 && y1 == 5, "R2", "u1 y frozen", y1, 5);
    tick_en = 1'b1;
    go_and_drain();

    // PAL, cropped window
    start(1, 1, 0);
    q(1, 5, 1, 1, 0, "R6");    q(1, 6, 1, 1, 0, "R6");
    q(1, 12, 1, 1, 0, "R6");   q(1, 13, 1, 1, 0, "R6");
    q(1, 17, 1, 1, 0, "R3");   q(1, 18, 1, 1, 0, "R3");
    q(1, 71, 1, 1, 0, "R6");   q(1, 72, 1, 1, 0, "R6");
    q(1, 197, 1, 1, 0, "R6");  q(1, 198, 1, 1, 0, "R6");
    q(1, 269, 1, 1, 0, "R3");  q(1, 270, 1, 1, 0, "R3");
    q(0, 627, 1, 1, 0, "R6");  q(0, 628, 1, 1, 0, "R6");
    q(0, 3187, 1, 1, 0, "R6"); q(0, 3188, 1, 1, 0, "R6");
    q(0, 3405, 1, 1, 0, "R3"); q(0, 3406, 1, 1, 0, "R3");
    go_and_drain();

    // NTSC, cropped window, then crop released mid-line
    start(0, 1, 0);
    q(1, 59, 0, 1, 0, "R6");   q(1, 60, 0, 1, 0, "R6");
    q(1, 179, 0, 1, 0, "R6");  q(1, 180, 0, 1, 0, "R6");
    q(0, 607, 0, 1, 0, "R6");  q(0, 608, 0, 1, 0, "R6");
    q(0, 3167, 0, 1, 0, "R6"); q(0, 3168, 0, 1, 0, "R6");
    go_and_drain();
    wait_tick(3700);
    tick_en = 1'b0;
    @(negedge clk);
    chk(hb0 == 1, "R6", "u0 hblank in crop margin", hb0, 1);
    crop_en = 1'b0;
    #1ns;
    // R6 crop change acts in the same cycle: x=287 of line 1 is blanked either way, x stays
    chk(hb0 == 1 && x0 == 287, "R6", "u0 x after crop drop", x0, 287);
    tick_en = 1'b1;
    wait_tick(3413 + 500);
    crop_en = 1'b1;
    #1ns;
    chk(hb0 == 1, "R6", "u0 hblank x=500 cropped", hb0, 1);
    crop_en = 1'b0;
    #1ns;
    chk(hb0 == 0, "R6", "u0 hblank x=500 full", hb0, 0);

    // PAL, full window
    start(1, 0, 0);
    q(1, 53, 1, 0, 0, "R5");   q(1, 54, 1, 0, 0, "R5");
    q(1, 215, 1, 0, 0, "R5");  q(1, 216, 1, 0, 0, "R5");
    q(0, 487, 1, 0, 0, "R4");  q(0, 488, 1, 0, 0, "R4");
    q(0, 3299, 1, 0, 0, "R4"); q(0, 3300, 1, 0, 0, "R4");
    go_and_drain();

    // NTSC with interlace, then interlace dropped
    start(0, 0, 1);
    q(1, 259, 0, 0, 1, "R7");  q(1, 260, 0, 0, 1, "R7");
    q(1, 280, 0, 0, 1, "R7");
    go_and_drain();
    wait_tick(300);
    il = 1'b0;
    @(negedge clk);
    chk(fd1 == 0, "R7", "u1 field cleared", fd1, 0);
    q(1, 520, 0, 0, 0, "R7");
    go_and_drain();

    // Standard switch mid-frame
    start(0, 0, 0);
    rst_n = 1'b1;
    wait_tick(50);
    pal_sel = 1'b1;
    q(1, 100, 0, 0, 0, "R8");
    q(1, 259, 0, 0, 0, "R8");
    begin
      item_t e;
      e = calc(1, 0, 1, 0, 0, "R8");   e.t = 260; sb.push_back(e);
      e = calc(1, 17, 1, 0, 0, "R8");  e.t = 277; sb.push_back(e);
      e = calc(1, 18, 1, 0, 0, "R8");  e.t = 278; sb.push_back(e);
    end
    q(0, 300, 0, 0, 0, "R8");
    go_and_drain();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule